// File: doc/BRIEF.md
# Clock Operating Mode Register with CPU Stall Control

This block is an 8-bit control register that picks the working mode of two clock sources, a fast main clock and a slow subsystem clock, and turns each choice into pin-function enables for the pad ring. The register can be written as a whole byte or one bit at a time, and it can always be read back. Bit 0 is a frequency-range flag. After reset, this flag may change value only once.

When the range flag goes from 0 to 1, a stall controller pulls the CPU clock enable low for a fixed interval. It does the same when a STOP-release pulse arrives while the flag is 1. If the CPU runs from an external clock input, the interval is a count of external clock ticks. Each tick reaches the block as a one-cycle pulse in the local clock domain. If the CPU runs from an oscillator, the interval is a count of local clock cycles that stands for the required microsecond window.

The stall controller has three states. RUN is the idle state, with the clock enabled. HOLD_EXT counts external ticks, and HOLD_OSC counts local cycles. A trigger seen in RUN moves the controller to HOLD_EXT or HOLD_OSC, depending on the source select. A trigger seen in either hold state reloads the counter and picks the hold state again from the source select. Each hold state returns to RUN when its count runs out.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00, cpu_clk_en is 1 and stall_busy is 0.
- R2: A byte write stores wr_data[7:4] and wr_data[0]. Bits 3:1 always read as 0.
- R3: A bit write with bit_idx 7, 6, 5 or 4 sets or clears that single bit, as given by bit_val. A bit write with bit_idx 3, 2 or 1 changes nothing.
- R4: Bit 0 (the range flag) can change only once after reset. A write that leaves bit 0 unchanged does not use up that change. Once bit 0 has changed, every later byte or bit write to it is ignored.
- R5: Bits 7:6 set the main clock mode and bits 5:4 set the subsystem clock mode. Within each pair, the upper bit selects external input and the lower bit selects the oscillator. Code 01 raises the oscillator enable for that clock, code 11 raises its clock-input enable, and codes 00 and 10 raise neither.
- R6: Suppose a stall starts while cpu_src_ext is 1. cpu_clk_en goes low in the cycle after the trigger. It stays low until the edge that samples the 160th ext_tick pulse, and it is 1 again after that edge. Cycles without a tick do not advance the count.
- R7: Suppose a stall starts while cpu_src_ext is 0. cpu_clk_en goes low in the cycle after the trigger and stays low for exactly OSC_STALL_CYCLES clock cycles. The default is 800, which is 8 us at 100 MHz.
- R8: A stop_release pulse starts a stall when bit 0 is 1. It has no effect when bit 0 is 0.
- R9: A trigger that arrives during a stall restarts the count from its full value.
- R10: stall_busy is 1 exactly in the cycles in which cpu_clk_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_idx | input | 3 | Bit position for the single-bit write |
| bit_val | input | 1 | Value for the single-bit write |
| rd_data | output | 8 | Register read-back |
| cpu_src_ext | input | 1 | 1 means the CPU runs from an external clock input |
| ext_tick | input | 1 | One pulse per external clock cycle |
| stop_release | input | 1 | Pulse when STOP mode ends |
| hs_osc_en | output | 1 | Main clock oscillator pins enabled |
| hs_clkin_en | output | 1 | Main clock external input pin enabled |
| sub_osc_en | output | 1 | Subsystem oscillator pins enabled |
| sub_clkin_en | output | 1 | Subsystem external input pin enabled |
| cpu_clk_en | output | 1 | CPU clock enable |
| stall_busy | output | 1 | A stall is in progress |

## Verification
The assertions check, on every cycle, that a locked range flag holds its value and that every trigger loads the counter with the value for the sampled source. They also check that the counter does not move in HOLD_EXT without a tick, that it steps down by one per cycle in HOLD_OSC, and that a set flag or a STOP exit with the flag set drops the clock enable. Some properties need a whole stall observed at the ports, and only the bench scenarios can show them. These are the exact length of each stall, the restart of an ongoing stall, the lack of any effect from ignored writes and from a STOP exit with the flag clear, and the pin-mode decodes.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HOLD_EXT = 2'd1,
        ST_HOLD_OSC = 2'd2
    } stall_state_e;

    localparam int unsigned MODE_W = 2;

    // Pin-function codes for one clock: {external-input, oscillator-select}
    localparam logic [MODE_W-1:0] MODE_OSC   = 2'b01;
    localparam logic [MODE_W-1:0] MODE_CLKIN = 2'b11;
endpackage

// File: rtl/clk_mode_reg.sv
module clk_mode_reg
    import clk_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       bit_wr_en,
    input  logic [2:0] bit_idx,
    input  logic       bit_val,
    output logic [7:0] reg_q,
    output logic       range_rise
);
    logic [MODE_W-1:0] hs_q, hs_d, sub_q, sub_d;
    logic              range_q, range_d, range_req, lock_q;

    always_comb begin
        hs_d      = hs_q;
        sub_d     = sub_q;
        range_req = range_q;
        if (wr_en) begin
            hs_d      = wr_data[7:6];
            sub_d     = wr_data[5:4];
            range_req = wr_data[0];
        end else if (bit_wr_en) begin
            case (bit_idx)
                3'd7:    hs_d[1]   = bit_val;
                3'd6:    hs_d[0]   = bit_val;
                3'd5:    sub_d[1]  = bit_val;
                3'd4:    sub_d[0]  = bit_val;
                3'd0:    range_req = bit_val;
                default: ;
            endcase
        end
        range_d    = lock_q ? range_q : range_req;
        range_rise = range_d & ~range_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q    <= '0;
            sub_q   <= '0;
            range_q <= 1'b0;
            lock_q  <= 1'b0;
        end else begin
            hs_q    <= hs_d;
            sub_q   <= sub_d;
            range_q <= range_d;
            lock_q  <= lock_q | (range_d != range_q);
        end
    end

    assign reg_q = {hs_q, sub_q, 3'b000, range_q};

    // R4
    range_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> $stable(range_q));
endmodule

// File: rtl/clk_stall_fsm.sv
module clk_stall_fsm
    import clk_mode_pkg::*;
#(
    parameter int unsigned EXT_STALL_TICKS  = 160,
    parameter int unsigned OSC_STALL_CYCLES = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic src_ext,
    input  logic ext_tick,
    output logic clk_en,
    output logic busy
);
    localparam int unsigned MAX_LD = (EXT_STALL_TICKS > OSC_STALL_CYCLES) ?
                                     EXT_STALL_TICKS : OSC_STALL_CYCLES;
    localparam int unsigned CNT_W  = $clog2(MAX_LD + 1);
    localparam logic [CNT_W-1:0] EXT_LD = CNT_W'(EXT_STALL_TICKS);
    localparam logic [CNT_W-1:0] OSC_LD = CNT_W'(OSC_STALL_CYCLES);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    stall_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_RUN, ST_HOLD_EXT, ST_HOLD_OSC: begin
                if (trig) begin
                    state_d = src_ext ? ST_HOLD_EXT : ST_HOLD_OSC;
                    cnt_d   = src_ext ? EXT_LD : OSC_LD;
                end else if (state_q == ST_HOLD_EXT && ext_tick) begin
                    if (cnt_q == ONE) state_d = ST_RUN;
                    cnt_d = cnt_q - ONE;
                end else if (state_q == ST_HOLD_OSC) begin
                    if (cnt_q == ONE) state_d = ST_RUN;
                    cnt_d = cnt_q - ONE;
                end
            end
            default: begin
                state_d = ST_RUN;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        clk_en = (state_q == ST_RUN);
        busy   = (state_q != ST_RUN);
    end

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt_q == ($past(src_ext) ? EXT_LD : OSC_LD)));
    // R6
    ext_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_EXT && !ext_tick && !trig) |=> $stable(cnt_q));
    // R7
    osc_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_OSC && !trig && cnt_q > ONE) |=>
            (cnt_q == $past(cnt_q) - ONE));
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
    import clk_mode_pkg::*;
#(
    parameter int unsigned EXT_STALL_TICKS  = 160,
    parameter int unsigned OSC_STALL_CYCLES = 800
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       bit_wr_en,
    input  logic [2:0] bit_idx,
    input  logic       bit_val,
    output logic [7:0] rd_data,
    input  logic       cpu_src_ext,
    input  logic       ext_tick,
    input  logic       stop_release,
    output logic       hs_osc_en,
    output logic       hs_clkin_en,
    output logic       sub_osc_en,
    output logic       sub_clkin_en,
    output logic       cpu_clk_en,
    output logic       stall_busy
);
    logic [7:0] reg_q;
    logic       range_rise, trig;

    clk_mode_reg u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .bit_wr_en (bit_wr_en),
        .bit_idx   (bit_idx),
        .bit_val   (bit_val),
        .reg_q     (reg_q),
        .range_rise(range_rise)
    );

    assign trig = range_rise | (stop_release & reg_q[0]);

    clk_stall_fsm #(
        .EXT_STALL_TICKS (EXT_STALL_TICKS),
        .OSC_STALL_CYCLES(OSC_STALL_CYCLES)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .src_ext (cpu_src_ext),
        .ext_tick(ext_tick),
        .clk_en  (cpu_clk_en),
        .busy    (stall_busy)
    );

    assign rd_data      = reg_q;
    assign hs_osc_en    = (reg_q[7:6] == MODE_OSC);
    assign hs_clkin_en  = (reg_q[7:6] == MODE_CLKIN);
    assign sub_osc_en   = (reg_q[5:4] == MODE_OSC);
    assign sub_clkin_en = (reg_q[5:4] == MODE_CLKIN);

    // R8
    stop_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_release && rd_data[0]) |=> !cpu_clk_en);
    // R6
    first_set_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[0]) |-> !cpu_clk_en);
endmodule

// File: tb/clk_mode_ctrl_tb.sv
module clk_mode_ctrl_tb;
    localparam int EXT_N = 160;
    localparam int OSC_N = 800;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, bit_wr_en = 1'b0, bit_val = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] bit_idx = '0;
    logic       cpu_src_ext = 1'b0, ext_tick = 1'b0, stop_release = 1'b0;
    logic [7:0] rd_data;
    logic       hs_osc_en, hs_clkin_en, sub_osc_en, sub_clkin_en;
    logic       cpu_clk_en, stall_busy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    clk_mode_ctrl #(.EXT_STALL_TICKS(EXT_N), .OSC_STALL_CYCLES(OSC_N)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .bit_wr_en(bit_wr_en), .bit_idx(bit_idx), .bit_val(bit_val),
        .rd_data(rd_data), .cpu_src_ext(cpu_src_ext), .ext_tick(ext_tick),
        .stop_release(stop_release), .hs_osc_en(hs_osc_en),
        .hs_clkin_en(hs_clkin_en), .sub_osc_en(sub_osc_en),
        .sub_clkin_en(sub_clkin_en), .cpu_clk_en(cpu_clk_en),
        .stall_busy(stall_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic byte_wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bit_wr(input int idx, input logic v);
        bit_wr_en = 1'b1; bit_idx = 3'(idx); bit_val = v;
        @(negedge clk);
        bit_wr_en = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_release = 1'b1;
        @(negedge clk);
        stop_release = 1'b0;
    endtask

    // Counts low cycles from now until cpu_clk_en returns, R10 checked each cycle
    task automatic measure_low(output int n);
        n = 0;
        while (!cpu_clk_en && n < 5000) begin
            if (stall_busy !== 1'b1) chk("R10 busy while low", stall_busy, 1);
            n++;
            @(negedge clk);
        end
        chk("R10 busy after stall", stall_busy, 0);
    endtask

    task automatic t_reset();
        chk("R1 reset rd_data", rd_data, 0);
        chk("R1 reset clk_en", cpu_clk_en, 1);
        chk("R1 reset busy", stall_busy, 0);
    endtask

    task automatic t_byte_fields();
        byte_wr(8'hFE);
        chk("R2 byte write masks 3:1", rd_data, 8'hF0);
        byte_wr(8'h50);
        chk("R2 byte write 0x50", rd_data, 8'h50);
        chk("R5 hs 01 osc", hs_osc_en, 1);
        chk("R5 hs 01 no clkin", hs_clkin_en, 0);
        chk("R5 sub 01 osc", sub_osc_en, 1);
        byte_wr(8'hE0);
        chk("R5 hs 11 clkin", hs_clkin_en, 1);
        chk("R5 hs 11 no osc", hs_osc_en, 0);
        chk("R5 sub 10 none", sub_osc_en + sub_clkin_en, 0);
        byte_wr(8'h00);
        chk("R4 write leaving bit0 clear keeps clk_en", cpu_clk_en, 1);
    endtask

    task automatic t_bit_ops();
        bit_wr(7, 1'b1);
        chk("R3 set bit7", rd_data, 8'h80);
        bit_wr(4, 1'b1);
        chk("R3 set bit4", rd_data, 8'h90);
        bit_wr(2, 1'b1);
        chk("R3 bit2 ignored", rd_data, 8'h90);
        bit_wr(7, 1'b0);
        chk("R3 clear bit7", rd_data, 8'h10);
        chk("R5 sub 01 osc via bits", sub_osc_en, 1);
    endtask

    task automatic t_stop_without_range();
        pulse_stop();
        chk("R8 stop with range 0 no stall", cpu_clk_en, 1);
        @(negedge clk);
        chk("R8 stop with range 0 still running", cpu_clk_en, 1);
    endtask

    task automatic t_first_set_osc();
        int n;
        cpu_src_ext = 1'b0;
        bit_wr(0, 1'b1);
        chk("R4 range bit set", rd_data[0], 1);
        chk("R7 low right after set", cpu_clk_en, 0);
        measure_low(n);
        chk("R7 osc stall length", n, OSC_N);
    endtask

    task automatic t_lock();
        byte_wr(8'h00);
        chk("R4 byte clear ignored", rd_data, 8'h01);
        bit_wr(0, 1'b0);
        chk("R4 bit clear ignored", rd_data[0], 1);
        chk("R4 ignored writes no stall", cpu_clk_en, 1);
    endtask

    task automatic t_stop_ext();
        cpu_src_ext = 1'b1;
        pulse_stop();
        chk("R8 stop with range 1 stalls", cpu_clk_en, 0);
        repeat (20) @(negedge clk);
        chk("R6 no ticks no progress", cpu_clk_en, 0);
        for (int i = 0; i < EXT_N - 1; i++) begin
            ext_tick = 1'b1; @(negedge clk);
            ext_tick = 1'b0; @(negedge clk);
        end
        chk("R6 low after 159 ticks", cpu_clk_en, 0);
        chk("R10 busy after 159 ticks", stall_busy, 1);
        ext_tick = 1'b1; @(negedge clk);
        ext_tick = 1'b0;
        chk("R6 high after 160th tick", cpu_clk_en, 1);
        chk("R10 busy clear", stall_busy, 0);
    endtask

    task automatic t_restart();
        int n;
        cpu_src_ext = 1'b0;
        pulse_stop();
        repeat (300) @(negedge clk);
        chk("R9 still low mid stall", cpu_clk_en, 0);
        pulse_stop();
        measure_low(n);
        chk("R9 restart gives full length", n, OSC_N);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_fields();
        t_bit_ops();
        t_stop_without_range();
        t_first_set_osc();
        t_lock();
        t_stop_ext();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule